// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block sits behind the digital audio input of a converter path and turns a three-wire stereo serial stream into parallel samples. The three wires are a bit clock, a word-select line and a data line. Every half-frame carries one 16-bit word, most significant bit first. The word-select level tells which channel the word belongs to. After each word arrives, the receiver presents it on a left or right sample output and pulses the matching valid strobe for one bit-clock cycle.

A 2-bit format code selects how words sit inside their half-frames. In left-justified framing the word starts at the word-select change. In I2S framing it starts one bit clock later. In right-justified framing it ends at the word-select change. The code may change at any time. The receiver adopts a new code only when the next left word begins, and it drops whatever frame was in flight at that point. The code value 11 is reserved: it raises an error flag and produces no samples.

Data, word select and the format code are sampled on the rising edge of the bit clock, and the whole block runs in that clock domain. Reset is asynchronous and active low. Its release is synchronised to the bit clock inside the block.

Top module: `ser_audio_rx`

## Requirements
- R1: While reset is asserted and after its release, both samples read zero, both strobes are low, and the error flag is low; the format in force after reset is right-justified (code 00).
- R2: Code 10 (left-justified), word select high marks the left channel. The MSB is the data bit sampled at the same rising edge that first sees the new word-select level. The word is output with its strobe in the cycle that follows the rising edge sampling its 16th bit.
- R3: Code 01 (I2S), word select low marks the left channel. The MSB is sampled one rising edge after the edge that first sees the new level. The strobe follows the edge sampling the 16th bit, and this holds even when that edge is the next word-select change.
- R4: Code 00 (right-justified), word select high marks the left channel. The word is the last 16 bits sampled before the edge that sees the next word-select change, and the strobe follows that edge.
- R5: Half-frames longer than 16 bit clocks work in every format. Padding bits, whether trailing (codes 10 and 01) or leading (code 00), do not affect the output word.
- R6: Each strobe lasts exactly one bit-clock cycle, the left and right strobes are never high together, and each sample output holds its value between its strobes.
- R7: A new format code takes effect at the first word-select change into its own left level. A word that would complete on that switching edge is discarded, and no spurious word is produced.
- R8: While the code is 11, the error flag is high from the next rising edge on and neither strobe rises; it falls one edge after the code leaves 11.
- R9: No word is output before the first word-select change seen after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Serial bit clock; all sampling on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ws_i | input | 1 | Word select (channel marker) |
| sd_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 2 | Format code: 00 right-justified, 01 I2S, 10 left-justified, 11 reserved |
| left_o | output | 16 | Last received left word |
| left_vld_o | output | 1 | One-cycle strobe: new left word on left_o |
| right_o | output | 16 | Last received right word |
| right_vld_o | output | 1 | One-cycle strobe: new right word on right_o |
| fmt_err_o | output | 1 | High while the format code is the reserved value |

## Verification
Suppose the bit counter drifts by one position or its preset is chosen for the wrong format. The next word would then appear shifted by one bit, or its strobe would land one edge early or late, and this shows within a single half-frame. Suppose the held format register or the channel marker goes wrong. A word would then be issued under the wrong channel, or a word that a format switch should drop would still come out. Both errors show at the first frame boundary after the fault. For these reasons every expected word is compared in order against both its value and its channel. Any strobe that arrives while no word is expected counts as a failure.

// File: rtl/ser_audio_pkg.sv
package ser_audio_pkg;

  // Run-time framing selection, code values are part of the register map.
  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_I2S = 2'b01,
    FMT_LJ  = 2'b10,
    FMT_RSV = 2'b11
  } fmt_e;

  // Word-select level that marks the left channel for a given framing.
  function automatic logic left_level(input fmt_e f);
    return (f != FMT_I2S);
  endfunction

endpackage

// File: rtl/ser_audio_frame.sv
// Word-select tracking, held format and channel of the word in flight.
module ser_audio_frame
  import ser_audio_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ws_i,
  input  fmt_e fmt_i,
  output logic trans_o,
  output logic switch_o,
  output logic synced_o,
  output fmt_e act_q_o,
  output fmt_e act_d_o,
  output logic chan_left_o,
  output logic err_o
);

  logic ws_q, ws_d;
  logic seen_q, seen_d;
  logic synced_q, synced_d;
  logic chan_q, chan_d;
  logic err_q, err_d;
  fmt_e act_q, act_d;
  logic trans, left_start;

  always_comb begin
    trans      = seen_q && (ws_i != ws_q);
    left_start = trans && (ws_i == left_level(fmt_i));
    act_d      = left_start ? fmt_i : act_q;
    ws_d       = ws_i;
    seen_d     = 1'b1;
    synced_d   = synced_q | trans;
    chan_d     = trans ? (ws_i == left_level(act_d)) : chan_q;
    err_d      = (fmt_i == FMT_RSV);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_q     <= 1'b0;
      seen_q   <= 1'b0;
      synced_q <= 1'b0;
      chan_q   <= 1'b0;
      err_q    <= 1'b0;
      act_q    <= FMT_RJ;
    end else begin
      ws_q     <= ws_d;
      seen_q   <= seen_d;
      synced_q <= synced_d;
      err_q    <= err_d;
      act_q    <= act_d;
      if (trans) chan_q <= chan_d;
    end
  end

  assign trans_o     = trans;
  assign switch_o    = left_start && (fmt_i != act_q);
  assign synced_o    = synced_q;
  assign act_q_o     = act_q;
  assign act_d_o     = act_d;
  assign chan_left_o = chan_q;
  assign err_o       = err_q;

  // R7: the held format only moves on an edge where word select changed
  p_fmt_switch_on_ws_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q != $past(act_q)) |-> (ws_q != $past(ws_q)));

endmodule

// File: rtl/ser_audio_asm.sv
// Sliding shift register and bit counter; decides when a word is complete.
module ser_audio_asm
  import ser_audio_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sd_i,
  input  logic         trans_i,
  input  logic         switch_i,
  input  logic         synced_i,
  input  fmt_e         fmt_old_i,
  input  fmt_e         fmt_new_i,
  input  logic         chan_left_i,
  output logic         done_o,
  output logic [W-1:0] data_o,
  output logic         left_o
);

  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [CW-1:0] FULL = CW'(W);

  logic [W-1:0]  sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic mid_end, i2s_end, rj_end;

  always_comb begin
    sh_d = {sh_q[W-2:0], sd_i};
    if (trans_i)                      cnt_d = (fmt_new_i == FMT_I2S) ? '0 : CW'(1);
    else if (synced_i && cnt_q < FULL) cnt_d = cnt_q + 1'b1;
    else                               cnt_d = cnt_q;

    mid_end = !trans_i && (cnt_q == LAST) &&
              ((fmt_old_i == FMT_LJ) || (fmt_old_i == FMT_I2S));
    i2s_end = trans_i && !switch_i && (fmt_old_i == FMT_I2S) && (cnt_q == LAST);
    rj_end  = trans_i && !switch_i && (fmt_old_i == FMT_RJ)  && (cnt_q == FULL);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign done_o = mid_end | i2s_end | rj_end;
  assign data_o = rj_end ? sh_q : sh_d;
  assign left_o = chan_left_i;

  // R5: the bit counter saturates at one full word however long the half-frame
  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);

endmodule

// File: rtl/ser_audio_rx.sv
module ser_audio_rx
  import ser_audio_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         bclk_i,
  input  logic         rst_ni,
  input  logic         ws_i,
  input  logic         sd_i,
  input  logic [1:0]   fmt_i,
  output logic [W-1:0] left_o,
  output logic         left_vld_o,
  output logic [W-1:0] right_o,
  output logic         right_vld_o,
  output logic         fmt_err_o
);

  logic [1:0] rst_sync_q;
  logic       rst_n;
  fmt_e       fmt_in;
  logic       trans, switch_now, synced, chan_left, err;
  fmt_e       act_q, act_d;
  logic       done, word_left;
  logic [W-1:0] word;
  logic       emit;
  logic [W-1:0] left_q, left_d, right_q, right_d;
  logic       lv_q, lv_d, rv_q, rv_d;

  always_ff @(posedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n  = rst_sync_q[1];
  assign fmt_in = fmt_e'(fmt_i);

  ser_audio_frame u_frame (
    .clk_i       (bclk_i),
    .rst_ni      (rst_n),
    .ws_i        (ws_i),
    .fmt_i       (fmt_in),
    .trans_o     (trans),
    .switch_o    (switch_now),
    .synced_o    (synced),
    .act_q_o     (act_q),
    .act_d_o     (act_d),
    .chan_left_o (chan_left),
    .err_o       (err)
  );

  ser_audio_asm #(.W(W)) u_asm (
    .clk_i       (bclk_i),
    .rst_ni      (rst_n),
    .sd_i        (sd_i),
    .trans_i     (trans),
    .switch_i    (switch_now),
    .synced_i    (synced),
    .fmt_old_i   (act_q),
    .fmt_new_i   (act_d),
    .chan_left_i (chan_left),
    .done_o      (done),
    .data_o      (word),
    .left_o      (word_left)
  );

  always_comb begin
    emit    = done && (fmt_in != FMT_RSV);
    lv_d    = emit && word_left;
    rv_d    = emit && !word_left;
    left_d  = lv_d ? word : left_q;
    right_d = rv_d ? word : right_q;
  end

  always_ff @(posedge bclk_i or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      right_q <= '0;
      lv_q    <= 1'b0;
      rv_q    <= 1'b0;
    end else begin
      lv_q <= lv_d;
      rv_q <= rv_d;
      if (lv_d) left_q  <= left_d;
      if (rv_d) right_q <= right_d;
    end
  end

  assign left_o      = left_q;
  assign right_o     = right_q;
  assign left_vld_o  = lv_q;
  assign right_vld_o = rv_q;
  assign fmt_err_o   = err;

  // R6: never both channels in one cycle
  p_strobe_excl_r6: assert property (@(posedge bclk_i) disable iff (!rst_n)
    !(left_vld_o && right_vld_o));
  // R6: a strobe is a single-cycle pulse
  p_left_pulse_r6: assert property (@(posedge bclk_i) disable iff (!rst_n)
    left_vld_o |=> !left_vld_o);
  // R6: sample holds between strobes
  p_left_hold_r6: assert property (@(posedge bclk_i) disable iff (!rst_n)
    !left_vld_o |-> $stable(left_o));
  // R8: reserved code silences both strobes
  p_err_quiet_r8: assert property (@(posedge bclk_i) disable iff (!rst_n)
    fmt_err_o |-> (!left_vld_o && !right_vld_o));

endmodule

// File: tb/sim_ser_audio_rx.sv
module sim_ser_audio_rx;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] F_RJ = 2'b00, F_I2S = 2'b01, F_LJ = 2'b10, F_RSV = 2'b11;

  logic bclk = 1'b0;
  logic rst_n = 1'b0;
  logic ws = 1'b0;
  logic sd = 1'b0;
  logic [1:0] fmt = F_RJ;
  logic [15:0] left_o, right_o;
  logic left_vld, right_vld, fmt_err;

  int checks = 0;
  int errors = 0;
  int strobes = 0;
  logic done = 1'b0;

  logic [16:0] exp_q[$];
  string       tag_q[$];
  logic [1:0]  cur_f = F_RJ;
  logic        hold = 1'b0;
  logic        pend_v = 1'b0;
  logic [15:0] pend_w = '0;
  string       pend_tag = "";
  logic [16:0] mon_e, mon_a;
  string       mon_t;
  int          snap;

  always #(CLK_PERIOD / 2) bclk = ~bclk;

  ser_audio_rx u0 (
    .bclk_i      (bclk),
    .rst_ni      (rst_n),
    .ws_i        (ws),
    .sd_i        (sd),
    .fmt_i       (fmt),
    .left_o      (left_o),
    .left_vld_o  (left_vld),
    .right_o     (right_o),
    .right_vld_o (right_vld),
    .fmt_err_o   (fmt_err)
  );

  function automatic logic lft(input logic [1:0] f);
    return f != F_I2S;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input logic l, input logic [15:0] w, input string t);
    exp_q.push_back({l, w});
    tag_q.push_back(t);
  endtask

  // fd: framing that sets the data delay of this slot; fn: code driven now
  task automatic drive_bit(input logic w, input logic b, input logic [1:0] fd, input logic [1:0] fn);
    @(negedge bclk);
    ws   = w;
    sd   = (fd == F_I2S) ? hold : b;
    hold = b;
    fmt  = fn;
  endtask

  task automatic drive_half(input logic w, input logic [15:0] word, input int n, input logic [1:0] f);
    for (int i = 0; i < n; i++) begin
      logic b;
      if (f == F_RJ) b = (i >= n - 16) ? word[n - 1 - i] : i[0];
      else           b = (i < 16) ? word[15 - i] : i[0];
      drive_bit(w, b, f, f);
    end
  endtask

  task automatic send_frame(input logic [1:0] f, input logic [15:0] l, input logic [15:0] r,
                            input int n, input string tag);
    if (f != cur_f) begin
      // R7: a word ending on the switching edge is dropped
      if (pend_v && f != F_RSV && (cur_f == F_I2S || (cur_f == F_RJ && lft(cur_f) != lft(f))))
        push(1'b0, pend_w, pend_tag);
      pend_v = 1'b0;
      for (int g = 0; g < 4; g++) drive_bit(!lft(f), 1'b0, cur_f, f);
      cur_f = f;
    end else if (pend_v) begin
      push(1'b0, pend_w, pend_tag);
      pend_v = 1'b0;
    end
    if (f != F_RSV) push(1'b1, l, tag);
    drive_half(lft(f), l, n, f);
    if (f != F_RSV) begin
      if (f == F_LJ || (f == F_I2S && n > 16)) push(1'b0, r, tag);
      else begin
        pend_v = 1'b1; pend_w = r; pend_tag = tag;
      end
    end
    drive_half(!lft(f), r, n, f);
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(negedge bclk);
      if (rst_n && (left_vld || right_vld)) begin
        strobes++;
        checks++;
        if (left_vld && right_vld) begin
          errors++;
          $display("FAIL R6: actual both strobes high expected one");
        end else if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R7: actual word %h left=%0b expected none",
                   left_vld ? left_o : right_o, left_vld);
        end else begin
          mon_e = exp_q.pop_front();
          mon_t = tag_q.pop_front();
          mon_a = {left_vld, left_vld ? left_o : right_o};
          if (mon_a !== mon_e) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", mon_t, mon_a, mon_e);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge bclk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge bclk);
    // R1: reset state
    chk(left_o, 0, "R1 left sample");
    chk(right_o, 0, "R1 right sample");
    chk({left_vld, right_vld}, 0, "R1 strobes");
    chk(fmt_err, 0, "R1 error flag");
    rst_n = 1'b1;
    // R9: no word before the first word-select change
    for (int k = 0; k < 20; k++) drive_bit(1'b0, 1'b1, F_RJ, F_RJ);
    chk(strobes, 0, "R9 no word before sync");
    chk({left_vld, right_vld, fmt_err}, 0, "R1 outputs after release");

    send_frame(F_RJ, 16'hA1B2, 16'hC3D4, 16, "R4 RJ n16");
    send_frame(F_RJ, 16'h8000, 16'h7FFF, 16, "R4 RJ extremes");
    send_frame(F_RJ, 16'h1234, 16'hFEDC, 20, "R5 RJ padded n20");
    // R7: right word of the last RJ frame is dropped at the switch to LJ
    send_frame(F_LJ, 16'h5A5A, 16'h0F0F, 16, "R2 LJ n16 R7 switch");
    send_frame(F_LJ, 16'hFFFF, 16'h0001, 24, "R5 LJ padded n24");
    send_frame(F_I2S, 16'h1357, 16'h2468, 16, "R3 I2S n16");
    send_frame(F_I2S, 16'h8001, 16'hBEEF, 16, "R3 I2S LSB on ws edge");
    send_frame(F_I2S, 16'hCAFE, 16'h0000, 18, "R5 I2S padded n18");
    snap = strobes;
    send_frame(F_RSV, 16'hDEAD, 16'hBEEF, 16, "R8");
    send_frame(F_RSV, 16'h1111, 16'h2222, 16, "R8");
    chk(fmt_err, 1, "R8 error flag high on code 11");
    chk(strobes - snap, 0, "R8 no words while code 11");
    send_frame(F_LJ, 16'h6C6C, 16'h9393, 16, "R7 LJ after reserved");
    chk(fmt_err, 0, "R8 error flag falls");
    send_frame(F_I2S, 16'h7E81, 16'h4242, 16, "R3 I2S before switch");
    send_frame(F_RJ, 16'h0FF0, 16'hF00F, 17, "R7 RJ after I2S");
    send_frame(F_RJ, 16'h3C3C, 16'hC3C3, 16, "R4 RJ n16 again");

    // flush the last pending word
    if (pend_v) push(1'b0, pend_w, pend_tag);
    pend_v = 1'b0;
    for (int k = 0; k < 8; k++) drive_bit(lft(cur_f), 1'b0, cur_f, cur_f);
    chk(exp_q.size(), 0, "R7 every expected word seen");
    chk(right_o, 16'hC3C3, "R6 right sample held");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule